// File: doc/BRIEF.md
# Serial Buffer Fill Status and Overrun Unit

This block tracks how full the transmit queue and the receive queue of a serial peripheral are. Each queue holds up to four transfers. The host bus and the shift engine give it push and pop strobes, and it turns them into two 3-bit fill counts. It does not store the transfer data itself.

Two programmable thresholds drive active-low fill-level interrupt indicators, one per queue. A sticky flag records that a transfer waiting in the transmit queue was overwritten before it went out. Software clears the flag by writing a 1 to its bit. Everything is presented as one 32-bit read-only status word.

A configuration-mode input returns the error state, the counts and the indicators to their reset values.

Top module: `spibs_status`

## Requirements
- R1: The status word holds the transmit indicator at bit 15, the receive indicator at bit 14, the transmit count at bits 13:11, the receive count at bits 10:8 and the overrun flag at bit 7. All other bits (31:16 and 6:0) always read 0.
- R2: After synchronous reset, both counts are 000, the overrun flag is 0, the transmit indicator is 1 and the receive indicator is 0.
- R3: A count goes up by one on a push and down by one on a pop. It encodes 000 for empty, 001 to 011 for one to three entries, and 100 for full. It never reaches 101 to 111. A receive push while the receive count is 100 leaves it at 100.
- R4: A push and a pop on the same queue in the same cycle leave a non-empty count unchanged. On an empty queue only the push takes effect, giving 001. A transmit push together with a pop at 100 raises no overrun.
- R5: A pop while a count is 000 is ignored, and the count stays 000.
- R6: A transmit push with no pop while the transmit count is 100 keeps the count at 100. It sets the overrun flag at the same clock edge.
- R7: A status write with the overrun bit set to 1 clears the flag. A write with that bit 0 leaves the flag unchanged.
- R8: When an overrun and a clearing write fall in the same cycle, the flag ends up set.
- R9: Any cycle with configuration mode high returns the overrun flag, both counts and both indicators to their reset values. This takes priority over all strobes.
- R10: Each cycle, the transmit indicator is loaded with 0 when the transmit count at that edge is at or below the transmit threshold, and with 1 otherwise. It therefore lags the count by one cycle.
- R11: Each cycle, the receive indicator is loaded with 0 when the receive count at that edge is at or above the receive threshold, and with 1 otherwise. It also lags the count by one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 1 | Configuration mode; flushes counts, flag and indicators |
| tx_push | input | 1 | Host wrote a transfer into the transmit queue |
| tx_pop | input | 1 | Shift engine took a transfer from the transmit queue |
| rx_push | input | 1 | Shift engine stored a received transfer |
| rx_pop | input | 1 | Host read a transfer from the receive queue |
| tx_thresh | input | 3 | Transmit indicator threshold (low-water mark) |
| rx_thresh | input | 3 | Receive indicator threshold (high-water mark) |
| stat_wr | input | 1 | Write strobe to the status word |
| stat_wr_ovr | input | 1 | Value written to the overrun bit (1 clears) |
| status | output | 32 | Packed status word |

## Verification
The bench sweeps all threshold pairs from 0 to 4 under pseudo-random strobe traffic and compares every field with an arithmetic model each cycle. It also aims directed stimulus at specific corners:
- Push with pop at empty and at full. A design that got this wrong would drop the push or raise a false overrun.
- Pops on an empty queue. A wrong design would wrap the count to 111.
- Pushes past full. A wrong design would emit code 101.
- An overrun in the same cycle as a clearing write, which a wrong design would lose.
- A write of 0 to the flag, which a wrong design would let clear it.
- A configuration pulse, which a design with the wrong priority would let a strobe survive.

// File: rtl/spibs_pkg.sv
package spibs_pkg;

    localparam int DEPTH = 4;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic push;
        logic pop;
    } strobe_t;

    typedef enum logic {
        CMP_AT_OR_BELOW = 1'b0,
        CMP_AT_OR_ABOVE = 1'b1
    } cmp_mode_e;

    typedef struct packed {
        logic [15:0] rsvd_hi;
        logic        tx_ind_n;
        logic        rx_ind_n;
        cnt_t        tx_cnt;
        cnt_t        rx_cnt;
        logic        ovr;
        logic [6:0]  rsvd_lo;
    } status_t;

    function automatic status_t build_status(logic tx_ind_n, logic rx_ind_n,
                                             cnt_t tx_cnt, cnt_t rx_cnt, logic ovr);
        status_t s;
        s          = '0;
        s.tx_ind_n = tx_ind_n;
        s.rx_ind_n = rx_ind_n;
        s.tx_cnt   = tx_cnt;
        s.rx_cnt   = rx_cnt;
        s.ovr      = ovr;
        return s;
    endfunction

endpackage

// File: rtl/spibs_fill.sv
module spibs_fill
    import spibs_pkg::*;
#(
    parameter int QDEPTH = DEPTH
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    flush,
    input  strobe_t stb,
    output cnt_t    cnt,
    output logic    overflow
);
    localparam cnt_t FULL = cnt_t'(QDEPTH);

    logic pop_ok;
    logic full;
    cnt_t nxt;

    assign pop_ok = stb.pop && (cnt != '0);
    assign full   = (cnt == FULL);

    always_comb begin
        nxt      = cnt;
        overflow = 1'b0;
        unique case ({stb.push, pop_ok})
            2'b10: begin
                if (full) overflow = 1'b1;
                else      nxt      = cnt + cnt_t'(1);
            end
            2'b01:   nxt = cnt - cnt_t'(1);
            default: nxt = cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || flush) cnt <= '0;
        else              cnt <= nxt;
    end

    // R3: count stays within the legal encodings
    a_r3_cnt_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL);

    // R4: simultaneous push and pop on a non-empty queue hold the count
    a_r4_push_pop_hold: assert property (@(posedge clk) disable iff (rst)
        (stb.push && stb.pop && cnt != '0 && !flush) |=> $stable(cnt));

    // R5: pop on an empty queue is ignored
    a_r5_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && stb.pop && !stb.push && !flush) |=> (cnt == '0));

    // R9: flush empties the queue
    a_r9_flush_cnt: assert property (@(posedge clk) disable iff (rst)
        flush |=> (cnt == '0));

endmodule

// File: rtl/spibs_level.sv
module spibs_level
    import spibs_pkg::*;
#(
    parameter cmp_mode_e MODE    = CMP_AT_OR_BELOW,
    parameter logic      RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  cnt_t cnt,
    input  cnt_t thr,
    output logic ind_n
);
    logic hit;

    generate
        if (MODE == CMP_AT_OR_BELOW) begin : g_low
            assign hit = (cnt <= thr);
        end else begin : g_high
            assign hit = (cnt >= thr);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || flush) ind_n <= RST_VAL;
        else              ind_n <= !hit;
    end

    // R9: flush returns the indicator to its reset value
    a_r9_flush_ind: assert property (@(posedge clk) disable iff (rst)
        flush |=> (ind_n == RST_VAL));

endmodule

// File: rtl/spibs_sticky.sv
module spibs_sticky (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst || flush) flag <= 1'b0;
        else if (set)     flag <= 1'b1;
        else if (clr)     flag <= 1'b0;
    end

    // R6 / R8: an overrun event always leaves the flag set
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        (set && !flush) |=> flag);

    // R7: without a set, a clear leaves the flag low
    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !flag);

    // R9: configuration mode clears the flag
    a_r9_flush_flag: assert property (@(posedge clk) disable iff (rst)
        flush |=> !flag);

endmodule

// File: rtl/spibs_status.sv
module spibs_status
    import spibs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_mode,
    input  logic        tx_push,
    input  logic        tx_pop,
    input  logic        rx_push,
    input  logic        rx_pop,
    input  logic [2:0]  tx_thresh,
    input  logic [2:0]  rx_thresh,
    input  logic        stat_wr,
    input  logic        stat_wr_ovr,
    output logic [31:0] status
);
    localparam cnt_t FULL = cnt_t'(DEPTH);

    strobe_t tx_stb, rx_stb;
    cnt_t    tx_cnt, rx_cnt;
    logic    tx_ovf, rx_ovf;
    logic    tx_ind_n, rx_ind_n;
    logic    ovr_flag;
    logic    ovr_clr;
    status_t st;

    assign tx_stb  = '{push: tx_push, pop: tx_pop};
    assign rx_stb  = '{push: rx_push, pop: rx_pop};
    assign ovr_clr = stat_wr && stat_wr_ovr;

    spibs_fill #(.QDEPTH(DEPTH)) u_tx_fill (
        .clk(clk), .rst(rst), .flush(cfg_mode),
        .stb(tx_stb), .cnt(tx_cnt), .overflow(tx_ovf)
    );

    spibs_fill #(.QDEPTH(DEPTH)) u_rx_fill (
        .clk(clk), .rst(rst), .flush(cfg_mode),
        .stb(rx_stb), .cnt(rx_cnt), .overflow(rx_ovf)
    );

    spibs_level #(.MODE(CMP_AT_OR_BELOW), .RST_VAL(1'b1)) u_tx_level (
        .clk(clk), .rst(rst), .flush(cfg_mode),
        .cnt(tx_cnt), .thr(tx_thresh), .ind_n(tx_ind_n)
    );

    spibs_level #(.MODE(CMP_AT_OR_ABOVE), .RST_VAL(1'b0)) u_rx_level (
        .clk(clk), .rst(rst), .flush(cfg_mode),
        .cnt(rx_cnt), .thr(rx_thresh), .ind_n(rx_ind_n)
    );

    spibs_sticky u_ovr (
        .clk(clk), .rst(rst), .flush(cfg_mode),
        .set(tx_ovf), .clr(ovr_clr), .flag(ovr_flag)
    );

    assign st     = build_status(tx_ind_n, rx_ind_n, tx_cnt, rx_cnt, ovr_flag);
    assign status = st;

    // R1: reserved bits read zero
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (status[31:16] == 16'h0) && (status[6:0] == 7'h0));

    // R3: receive push at full saturates
    a_r3_rx_saturate: assert property (@(posedge clk) disable iff (rst)
        (rx_ovf && !cfg_mode) |=> (status[10:8] == FULL));

    // R6: transmit overrun keeps the count full and sets the flag
    a_r6_tx_overrun: assert property (@(posedge clk) disable iff (rst)
        (tx_push && !tx_pop && status[13:11] == FULL && !cfg_mode)
        |=> (status[13:11] == FULL) && status[7]);

    // R10: transmit indicator low after a count at or below threshold
    a_r10_tx_ind: assert property (@(posedge clk) disable iff (rst)
        (!cfg_mode && status[13:11] <= tx_thresh) |=> !status[15]);

    // R11: receive indicator low after a count at or above threshold
    a_r11_rx_ind: assert property (@(posedge clk) disable iff (rst)
        (!cfg_mode && status[10:8] >= rx_thresh) |=> !status[14]);

endmodule

// File: tb/sim_spibs_status.sv
module sim_spibs_status;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_mode = 1'b0;
    logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [2:0]  tx_thresh = 3'd0, rx_thresh = 3'd0;
    logic        stat_wr = 1'b0, stat_wr_ovr = 1'b0;
    logic [31:0] status;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    int   m_tc = 0, m_rc = 0;
    logic m_ovr = 1'b0, m_ti = 1'b1, m_ri = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    spibs_status u0 (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode),
        .tx_push(tx_push), .tx_pop(tx_pop), .rx_push(rx_push), .rx_pop(rx_pop),
        .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
        .stat_wr(stat_wr), .stat_wr_ovr(stat_wr_ovr), .status(status)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_all();
        check("R1 reserved", {status[31:16], 9'h0, status[6:0]}, 32'h0);
        check("R3 tx count", 32'(status[13:11]), 32'(m_tc));
        check("R3 rx count", 32'(status[10:8]), 32'(m_rc));
        check("R6 overrun flag", 32'(status[7]), 32'(m_ovr));
        check("R10 tx indicator", 32'(status[15]), 32'(m_ti));
        check("R11 rx indicator", 32'(status[14]), 32'(m_ri));
    endtask

    task automatic model_edge();
        bit tpv, rpv, ev;
        if (rst || cfg_mode) begin
            m_tc = 0; m_rc = 0; m_ovr = 1'b0; m_ti = 1'b1; m_ri = 1'b0;
            return;
        end
        m_ti = !(m_tc <= int'(tx_thresh));
        m_ri = !(m_rc >= int'(rx_thresh));
        tpv = tx_pop && m_tc > 0;
        rpv = rx_pop && m_rc > 0;
        ev  = tx_push && !tpv && m_tc == 4;
        if (!ev) m_tc = m_tc + int'(tx_push) - int'(tpv);
        if (!(rx_push && !rpv && m_rc == 4)) m_rc = m_rc + int'(rx_push) - int'(rpv);
        if (ev) m_ovr = 1'b1;
        else if (stat_wr && stat_wr_ovr) m_ovr = 1'b0;
    endtask

    task automatic step(bit tp, bit tpo, bit rp, bit rpo, bit wr, bit wv, bit cf);
        @(negedge clk);
        tx_push = tp; tx_pop = tpo; rx_push = rp; rx_pop = rpo;
        stat_wr = wr; stat_wr_ovr = wv; cfg_mode = cf;
        @(posedge clk);
        model_edge();
        #1;
        check_all();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        step(0, 0, 0, 0, 0, 0, 0);
        rst = 1'b0;
        // R2: reset values
        check("R2 reset word", status, 32'h0000_8000);

        tx_thresh = 3'd1; rx_thresh = 3'd3;

        // R5: pops on empty ignored
        step(0, 1, 0, 1, 0, 0, 0);
        check("R5 empty pop", 32'(status[13:8]), 32'h0);

        // R4: push+pop at empty gives one entry
        step(1, 1, 1, 1, 0, 0, 0);
        check("R4 empty push+pop", 32'(status[13:8]), 32'b001_001);

        // R3: fill both queues up to full
        for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 0, 0, 0);
        check("R3 full code", 32'(status[13:8]), 32'b100_100);

        // R3: rx push at full saturates
        step(0, 0, 1, 0, 0, 0, 0);
        check("R3 rx saturate", 32'(status[10:8]), 32'd4);

        // R4: push+pop at full holds with no overrun
        step(1, 1, 1, 1, 0, 0, 0);
        check("R4 full push+pop", {status[13:7]}, 32'b100_100_0);

        // R6: overrun on push to full
        step(1, 0, 0, 0, 0, 0, 0);
        check("R6 overrun set", {status[13:11], status[7]}, 32'b100_1);

        // R7: write of 0 ignored
        step(0, 0, 0, 0, 1, 0, 0);
        check("R7 write zero keeps flag", 32'(status[7]), 32'd1);

        // R7: write 1 clears
        step(0, 0, 0, 0, 1, 1, 0);
        check("R7 write one clears", 32'(status[7]), 32'd0);

        // R8: set beats clear
        step(1, 0, 0, 0, 1, 1, 0);
        check("R8 set wins", 32'(status[7]), 32'd1);

        // R9: configuration mode flushes even with strobes
        step(1, 0, 1, 0, 0, 0, 1);
        check("R9 cfg flush", status, 32'h0000_8000);
        step(0, 0, 0, 0, 0, 0, 0);

        // R10 / R11: sweep all threshold pairs under pseudo-random traffic
        for (int t = 0; t <= 4; t++) begin
            for (int r = 0; r <= 4; r++) begin
                tx_thresh = 3'(t);
                rx_thresh = 3'(r);
                for (int c = 0; c < 60; c++) begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    step(lfsr[0], lfsr[1] & lfsr[5], lfsr[2], lfsr[3] & lfsr[6],
                         lfsr[4] & lfsr[7], lfsr[8],
                         (lfsr[15:9] == 7'h0));
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) cycles++;

endmodule